// File: doc/BRIEF.md
# Programmable SCL Clock Divider

This block turns a fast I/O clock into the serial clock of an I2C master. The division is the product of three factors. The first is a high-phase divisor `thp`, which is loaded on its own. The second is a prescaler of 2^n. The third is a linear factor (m+1). The values m and n come packed together in one 7-bit control word. A single prescale counter emits one base tick every (thp+1)·2^n·(m+1) I/O clocks. A phase counter then spends ten base ticks in each half of the SCL period. The serial clock frequency is therefore ioclk / (20·(thp+1)·2^n·(m+1)), with an exact 50% duty cycle.

Alongside the waveform, the block gives the byte engine three one-cycle timing strobes:
- a strobe in the middle of the low half, where SDA may change;
- a strobe in the middle of the high half, where SDA is sampled;
- a strobe at the start of every period, which coincides with the falling edge of SCL.

New divider values are written to a pending copy. The counters adopt them only at a period boundary, or at once while the divider is disabled. A period that is running therefore never changes shape.

Top module: `scl_divider`

## Requirements
- R1: After reset, the high-phase divisor is 24 and both m and n are 0. With `enable` low, `scl_o` is high and all three strobes are low.
- R2: While enabled, one SCL period lasts exactly 20·(thp+1)·2^n·(m+1) clock cycles. Consecutive `tick_wrap_o` pulses are that many cycles apart.
- R3: `ctl_val` bits 6:3 carry m (the factor is m+1), and bits 2:0 carry n (the prescale is 2^n). `ctl_load` high captures both fields. `thp_load` high captures `thp_val`.
- R4: `scl_o` is high for exactly half of each period (10·(thp+1)·2^n·(m+1) cycles). The high half follows the low half.
- R5: `tick_lo_o` pulses for one cycle in the middle of the low half. `tick_hi_o` pulses for one cycle in the middle of the high half. The two pulses are half a period apart, and they never overlap each other or `tick_wrap_o`.
- R6: `tick_wrap_o` pulses in the first cycle of each period, which is the cycle in which `scl_o` has just fallen. This cycle is a quarter period after `tick_hi_o`.
- R7: Values loaded while the divider runs do not alter the period in progress. They take effect from the next period boundary.
- R8: Lowering `enable` stops all strobes and holds `scl_o` high. Raising it restarts the counters from the start of a low half, so `tick_lo_o` appears a quarter period after the first enabled clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the divider; low holds SCL released high |
| ctl_load | input | 1 | Capture `ctl_val` into the pending configuration |
| ctl_val | input | 7 | Packed divider word, {m[3:0], n[2:0]} |
| thp_load | input | 1 | Capture `thp_val` into the pending configuration |
| thp_val | input | THP_W | High-phase divisor value |
| scl_o | output | 1 | Serial clock waveform |
| tick_lo_o | output | 1 | Strobe at the middle of SCL low |
| tick_hi_o | output | 1 | Strobe at the middle of SCL high |
| tick_wrap_o | output | 1 | Strobe at the start of each SCL period |

## Verification
The hardest case to reach from the ports is a configuration change in the middle of a running period. The divider has to finish the old period with the old span and only then switch. The stimulus therefore waits for a period boundary, lets a few cycles pass, loads a larger divisor, and then measures two consecutive periods separately. Counter restart is reached by toggling `enable` and timing the first low-half strobe against the first enabled clock edge. Several (thp, m, n) sets are chosen so that exchanging the m and n fields gives a different period.

// File: rtl/scl_divider.sv
module scl_divider #(
  parameter int THP_W   = 7,
  parameter int THP_RST = 24,
  parameter int M_W     = 4,
  parameter int N_W     = 3,
  parameter int HALF    = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               ctl_load,
  input  logic [M_W+N_W-1:0] ctl_val,
  input  logic               thp_load,
  input  logic [THP_W-1:0]   thp_val,
  output logic               scl_o,
  output logic               tick_lo_o,
  output logic               tick_hi_o,
  output logic               tick_wrap_o
);
  localparam int PRE_W = THP_W + 1 + (1 << N_W) - 1 + M_W + 1;
  localparam int PH_W  = $clog2(2 * HALF);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * HALF - 1);
  localparam logic [PH_W-1:0] PH_LO   = PH_W'(HALF / 2 - 1);
  localparam logic [PH_W-1:0] PH_HI   = PH_W'(HALF + HALF / 2 - 1);

  logic [THP_W-1:0] thp_p, thp_a;
  logic [M_W-1:0]   m_p, m_a;
  logic [N_W-1:0]   n_p, n_a;
  logic [PRE_W-1:0] pc;
  logic [PH_W-1:0]  ph;

  logic [PRE_W-1:0] thp_term, scaled, span;
  assign thp_term = PRE_W'(thp_a) + PRE_W'(1);
  assign scaled   = thp_term << n_a;
  assign span     = scaled * (PRE_W'(m_a) + PRE_W'(1));

  logic base_tick, last_ph;
  assign base_tick = enable && (pc == span - PRE_W'(1));
  assign last_ph   = (ph == PH_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thp_p <= THP_W'(THP_RST);
      m_p   <= '0;
      n_p   <= '0;
    end else begin
      if (thp_load) thp_p <= thp_val;
      if (ctl_load) {m_p, n_p} <= ctl_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thp_a <= THP_W'(THP_RST);
      m_a   <= '0;
      n_a   <= '0;
      pc    <= '0;
      ph    <= '0;
    end else if (!enable) begin
      thp_a <= thp_p;
      m_a   <= m_p;
      n_a   <= n_p;
      pc    <= '0;
      ph    <= '0;
    end else if (base_tick) begin
      pc <= '0;
      if (last_ph) begin
        ph    <= '0;
        thp_a <= thp_p;
        m_a   <= m_p;
        n_a   <= n_p;
      end else begin
        ph <= ph + PH_W'(1);
      end
    end else begin
      pc <= pc + PRE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_lo_o   <= 1'b0;
      tick_hi_o   <= 1'b0;
      tick_wrap_o <= 1'b0;
    end else begin
      tick_lo_o   <= base_tick && (ph == PH_LO);
      tick_hi_o   <= base_tick && (ph == PH_HI);
      tick_wrap_o <= base_tick && last_ph;
    end
  end

  assign scl_o = !enable || (ph >= PH_W'(HALF));
endmodule

module scl_divider_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic scl_o,
  input logic tick_lo_o,
  input logic tick_hi_o,
  input logic tick_wrap_o
);
  // R5
  strobes_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tick_lo_o, tick_hi_o, tick_wrap_o}));

  // R6
  wrap_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tick_wrap_o) |-> $fell(scl_o));

  // R5
  lo_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tick_lo_o) |-> !scl_o);

  // R5
  hi_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tick_hi_o) |-> scl_o);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !(tick_lo_o || tick_hi_o || tick_wrap_o));
endmodule

bind scl_divider scl_divider_chk chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .scl_o(scl_o),
  .tick_lo_o(tick_lo_o), .tick_hi_o(tick_hi_o), .tick_wrap_o(tick_wrap_o)
);

// File: tb/scl_divider_tb.sv
module scl_divider_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic ctl_load = 1'b0;
  logic [6:0] ctl_val = '0;
  logic thp_load = 1'b0;
  logic [6:0] thp_val = '0;
  logic scl_o, tick_lo_o, tick_hi_o, tick_wrap_o;

  int cyc = 0;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  scl_divider dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .ctl_load(ctl_load), .ctl_val(ctl_val),
    .thp_load(thp_load), .thp_val(thp_val),
    .scl_o(scl_o), .tick_lo_o(tick_lo_o), .tick_hi_o(tick_hi_o),
    .tick_wrap_o(tick_wrap_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic sig(input int sel);
    case (sel)
      0: return tick_lo_o;
      1: return tick_hi_o;
      default: return tick_wrap_o;
    endcase
  endfunction

  task automatic wait_sig(input int sel, output int t);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sig(sel) && n < 20000);
    t = cyc;
  endtask

  task automatic load_cfg(input int thp, input int m, input int n);
    @(negedge clk);
    thp_load = 1'b1;
    thp_val  = 7'(thp);
    ctl_load = 1'b1;
    ctl_val  = {4'(m), 3'(n)};
    @(negedge clk);
    thp_load = 1'b0;
    ctl_load = 1'b0;
  endtask

  task automatic run_cfg(input bit do_load, input int thp, input int m, input int n, input string tag);
    int l, k, t_lo, t_hi, t_wr, hi_cnt;
    l = (thp + 1) * (1 << n) * (m + 1);
    @(negedge clk);
    enable = 1'b0;
    if (do_load) load_cfg(thp, m, n);
    repeat (3) @(negedge clk);
    enable = 1'b1;
    k = cyc;
    wait_sig(0, t_lo);
    chk(t_lo - k == 5 * l, {"R8 first low strobe ", tag}, t_lo - k, 5 * l);
    wait_sig(1, t_hi);
    chk(t_hi - t_lo == 10 * l, {"R5 low-to-high strobe ", tag}, t_hi - t_lo, 10 * l);
    wait_sig(2, t_wr);
    chk(t_wr - t_hi == 5 * l, {"R6 high strobe to wrap ", tag}, t_wr - t_hi, 5 * l);
    chk(scl_o == 1'b0, {"R6 scl low at wrap ", tag}, scl_o, 0);
    hi_cnt = 0;
    for (int i = 0; i < 20 * l; i++) begin
      @(negedge clk);
      if (scl_o) hi_cnt++;
    end
    chk(hi_cnt == 10 * l, {"R4 high-time ", tag}, hi_cnt, 10 * l);
    chk(tick_wrap_o == 1'b1 && cyc - t_wr == 20 * l, {"R2 R3 period ", tag}, cyc - t_wr, 20 * l);
  endtask

  task automatic test_reset();
    int cnt = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!scl_o || tick_lo_o || tick_hi_o || tick_wrap_o) cnt++;
    end
    chk(cnt == 0, "R1 idle after reset", cnt, 0);
    run_cfg(1'b0, 24, 0, 0, "defaults");
  endtask

  task automatic test_disable();
    int cnt = 0;
    run_cfg(1'b1, 1, 0, 0, "pre-disable");
    repeat (7) @(negedge clk);
    enable = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (i > 0 && (!scl_o || tick_lo_o || tick_hi_o || tick_wrap_o)) cnt++;
    end
    chk(cnt == 0, "R8 disabled quiet", cnt, 0);
    run_cfg(1'b0, 1, 0, 0, "restart");
  endtask

  task automatic test_boundary();
    int t0, t1, t2;
    run_cfg(1'b1, 1, 0, 0, "boundary base");
    t0 = cyc;
    repeat (7) @(negedge clk);
    thp_load = 1'b1;
    thp_val  = 7'd3;
    @(negedge clk);
    thp_load = 1'b0;
    wait_sig(2, t1);
    chk(t1 - t0 == 40, "R7 old period kept", t1 - t0, 40);
    wait_sig(2, t2);
    chk(t2 - t1 == 80, "R7 new period applied", t2 - t1, 80);
  endtask

  initial begin
    test_reset();
    run_cfg(1'b1, 0, 0, 0, "unit span");
    run_cfg(1'b1, 2, 1, 2, "m1 n2");
    run_cfg(1'b1, 5, 3, 1, "m3 n1");
    run_cfg(1'b1, 6, 0, 3, "n3");
    test_disable();
    test_boundary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule